// File: doc/BRIEF.md
# Handset Power Sequencer with Supervisory Watchdog

This block decides when the supply rails of a battery-powered handset are on. A fresh press of the active-low power key or a fresh charger connection turns the rails on. The block then holds the system reset low for a programmable number of clock ticks. After that it runs the handset until a supervisory watchdog runs out or software asks for power-off. While reset is held, the block also takes control of several shared lines: the sleep control, the charger-detect indication, the charging PWM and the two measurement switches.

The host processor programs the block through a write-only three-wire serial link. The link has a chip select, a clock and data, and it is oversampled by the block clock. Every frame carries exactly eight bits, most significant bit first. The frame holds a 2-bit register selector followed by a 6-bit value. Register contents live until the block's own reset, which models battery attachment. They therefore survive any number of power cycles. All other inputs are taken as already synchronous to the block clock.

Top module: `pwrseq_top`

## Requirements
- R1: After reset every output is low. While the rails are off, a falling edge on `pwrKeyN` or a rising edge on `chargerIn` turns `railEn` on at the next clock edge.
- R2: Once the rails come on, `purxN` stays low for exactly POR_TICKS clock cycles and then goes high.
- R3: From power-up, `pwmOut` is forced high through the reset hold and beyond it, until the first accepted write to selector 2. After that write, `pwmOut` is high for `duty` cycles out of every 64, where `duty` is the written 6-bit value (0 means always low).
- R4: `sleepCtrl` is high during the reset hold, follows `asicSleep` once reset has released, and is low while the rails are off.
- R5: `chgDetOut` is low unless reset has released. After release it equals `chargerIn`.
- R6: Selector 0 holds the switch bits: value bit 0 enables `batSwEn` and value bit 1 enables `chgSwEn`. Both outputs are low whenever reset is not released.
- R7: The watchdog counts from power-up, through the reset hold, and is reloaded when reset releases. Its timeout is the length register (selector 1, default WD_DEFAULT) times WD_UNIT cycles. Writing a nonzero value to selector 1 stores it and restarts the timeout. On expiry the rails go off. The stored length survives power cycles.
- R8: Writing value 0 to selector 1 does not change the stored length. It turns the rails off KILL_TICKS cycles later, and bus writes are ignored in the meantime.
- R9: After any power-off, a key held low or a charger left connected does not power up again. Only a new key press or a new charger insertion does.
- R10: A frame takes effect when chip select rises, and only if exactly 8 bits were clocked on rising `sclk`. The bits are `{sel[1:0], value[5:0]}`, MSB first. Frames with any other bit count, frames sent while reset is not released, and frames to selector 3 are ignored.
- R11: If the reset-hold delay ends in the same cycle the watchdog expires, the power-off wins and `purxN` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset (battery attach) |
| pwrKeyN | input | 1 | Power key, low when pressed |
| chargerIn | input | 1 | Charger present indication |
| asicSleep | input | 1 | Sleep request from the host ASIC |
| sclk | input | 1 | Serial link clock |
| sdata | input | 1 | Serial link data |
| scsN | input | 1 | Serial link chip select, active low |
| railEn | output | 1 | Supply rail enable |
| purxN | output | 1 | System reset, active low |
| pwmOut | output | 1 | Charging PWM enable |
| sleepCtrl | output | 1 | Sleep control to the clock regulator |
| chgDetOut | output | 1 | Charger-detect indication, active high |
| batSwEn | output | 1 | Battery measurement switch enable |
| chgSwEn | output | 1 | Charger measurement switch enable |

## Verification
The end of the reset hold and the expiry of the watchdog can land on the same clock edge, because both counters start at power-up. The bench provokes this case directly. It first stores a watchdog length whose tick count equals the reset-hold delay, then powers off and presses the key again. It judges the outcome at the ports: the rails must drop at the end of the hold, and `purxN` must not show a single rising edge.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int ADDR_W     = 2;
  localparam int VAL_W      = 6;
  localparam int FRAME_BITS = ADDR_W + VAL_W;

  localparam logic [ADDR_W-1:0] SEL_SWITCH = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_WDLEN  = 2'd1;
  localparam logic [ADDR_W-1:0] SEL_DUTY   = 2'd2;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_HOLD = 2'd1,
    PS_RUN  = 2'd2,
    PS_KILL = 2'd3
  } pwrState_t;

  typedef struct packed {
    logic porLoad;
    logic wdLoadLen;
    logic wdLoadKill;
    logic wdRun;
    logic busEn;
    logic forceSet;
  } seqStrobe_t;
endpackage

// File: rtl/pwrseq_serial.sv
module pwrseq_serial
  import pwrseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              scsN,
  output logic              frameValid,
  output logic [ADDR_W-1:0] frameAddr,
  output logic [VAL_W-1:0]  frameVal
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic                  sclkPrev;
  logic                  csPrev;
  logic [FRAME_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]      bitCnt;
  logic                  sclkRise;

  assign sclkRise = sclk && !sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      sclkPrev <= sclk;
      csPrev   <= scsN;
      if (scsN) begin
        bitCnt <= '0;
      end else if (sclkRise) begin
        shiftReg <= {shiftReg[FRAME_BITS-2:0], sdata};
        if (bitCnt != CNT_OVER) bitCnt <= bitCnt + CNT_W'(1);
      end
    end
  end

  assign frameValid = scsN && !csPrev && (bitCnt == CNT_FULL);
  assign frameAddr  = shiftReg[FRAME_BITS-1 -: ADDR_W];
  assign frameVal   = shiftReg[VAL_W-1:0];
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrKeyN,
  input  logic              chargerIn,
  input  logic              frameValid,
  input  logic [ADDR_W-1:0] frameAddr,
  input  logic [VAL_W-1:0]  frameVal,
  input  logic              porDone,
  input  logic              wdExpired,
  output pwrState_t         state,
  output seqStrobe_t        strobe
);
  logic      keyPrev;
  logic      chgPrev;
  logic      wake;
  logic      killReq;
  pwrState_t nextState;

  assign wake    = (!pwrKeyN && keyPrev) || (chargerIn && !chgPrev);
  assign killReq = frameValid && (frameAddr == SEL_WDLEN) && (frameVal == '0);

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      PS_OFF: begin
        if (wake) begin
          nextState        = PS_HOLD;
          strobe.porLoad   = 1'b1;
          strobe.wdLoadLen = 1'b1;
          strobe.forceSet  = 1'b1;
        end
      end
      PS_HOLD: begin
        strobe.wdRun = 1'b1;
        if (wdExpired) begin
          nextState = PS_OFF;
        end else if (porDone) begin
          nextState        = PS_RUN;
          strobe.wdLoadLen = 1'b1;
        end
      end
      PS_RUN: begin
        strobe.wdRun = 1'b1;
        strobe.busEn = 1'b1;
        if (wdExpired) begin
          nextState = PS_OFF;
        end else if (killReq) begin
          nextState         = PS_KILL;
          strobe.wdLoadKill = 1'b1;
        end
      end
      PS_KILL: begin
        strobe.wdRun = 1'b1;
        if (wdExpired) nextState = PS_OFF;
      end
      default: nextState = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PS_OFF;
      keyPrev <= 1'b1;
      chgPrev <= 1'b0;
    end else begin
      state   <= nextState;
      keyPrev <= pwrKeyN;
      chgPrev <= chargerIn;
    end
  end
endmodule

// File: rtl/pwrseq_datapath.sv
module pwrseq_datapath
  import pwrseq_pkg::*;
#(
  parameter int POR_TICKS  = 3277,
  parameter int WD_UNIT    = 32768,
  parameter int KILL_TICKS = 16,
  parameter int WD_DEFAULT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              frameValid,
  input  logic [ADDR_W-1:0] frameAddr,
  input  logic [VAL_W-1:0]  frameVal,
  output logic              porDone,
  output logic              wdExpired,
  output logic              swBat,
  output logic              swChg,
  output logic              pwmForced,
  output logic              pwmLevel
);
  localparam int POR_W  = $clog2(POR_TICKS + 1);
  localparam int WD_MAX = ((1 << VAL_W) - 1) * WD_UNIT;
  localparam int WD_W   = $clog2(WD_MAX + 1);

  logic [POR_W-1:0] porCnt;
  logic [WD_W-1:0]  wdCnt;
  logic [1:0]       swReg;
  logic [VAL_W-1:0] wdLen;
  logic [VAL_W-1:0] duty;
  logic [VAL_W-1:0] pwmCnt;
  logic             busWrite;
  logic             wdWrite;
  logic [WD_W-1:0]  lenTicks;
  logic [WD_W-1:0]  ackTicks;

  assign busWrite = frameValid && strobe.busEn;
  assign wdWrite  = busWrite && (frameAddr == SEL_WDLEN) && (frameVal != '0);
  assign lenTicks = WD_W'(wdLen) * WD_W'(WD_UNIT) - WD_W'(1);
  assign ackTicks = WD_W'(frameVal) * WD_W'(WD_UNIT) - WD_W'(1);

  // reset-hold delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                porCnt <= '0;
    else if (strobe.porLoad)  porCnt <= POR_W'(POR_TICKS - 1);
    else if (porCnt != '0)    porCnt <= porCnt - POR_W'(1);
  end
  assign porDone = (porCnt == '0);

  // watchdog down-counter: kill load beats length load beats countdown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         wdCnt <= '0;
    else if (strobe.wdLoadKill)        wdCnt <= WD_W'(KILL_TICKS - 1);
    else if (strobe.wdLoadLen)         wdCnt <= lenTicks;
    else if (wdWrite)                  wdCnt <= ackTicks;
    else if (strobe.wdRun && wdCnt != '0) wdCnt <= wdCnt - WD_W'(1);
  end
  assign wdExpired = strobe.wdRun && (wdCnt == '0);

  // software-visible registers, kept across power cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swReg     <= '0;
      wdLen     <= VAL_W'(WD_DEFAULT);
      duty      <= '0;
      pwmForced <= 1'b0;
    end else begin
      if (busWrite && frameAddr == SEL_SWITCH) swReg <= frameVal[1:0];
      if (wdWrite) wdLen <= frameVal;
      if (strobe.forceSet) begin
        pwmForced <= 1'b1;
      end else if (busWrite && frameAddr == SEL_DUTY) begin
        duty      <= frameVal;
        pwmForced <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmCnt <= '0;
    else       pwmCnt <= pwmCnt + VAL_W'(1);
  end

  assign pwmLevel = (pwmCnt < duty);
  assign swBat    = swReg[0];
  assign swChg    = swReg[1];
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int POR_TICKS  = 3277,
  parameter int WD_UNIT    = 32768,
  parameter int KILL_TICKS = 16,
  parameter int WD_DEFAULT = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrKeyN,
  input  logic chargerIn,
  input  logic asicSleep,
  input  logic sclk,
  input  logic sdata,
  input  logic scsN,
  output logic railEn,
  output logic purxN,
  output logic pwmOut,
  output logic sleepCtrl,
  output logic chgDetOut,
  output logic batSwEn,
  output logic chgSwEn
);
  pwrState_t         state;
  seqStrobe_t        strobe;
  logic              frameValid;
  logic [ADDR_W-1:0] frameAddr;
  logic [VAL_W-1:0]  frameVal;
  logic              porDone;
  logic              wdExpired;
  logic              swBat;
  logic              swChg;
  logic              pwmForced;
  logic              pwmLevel;
  logic              released;
  logic              holding;

  pwrseq_serial u_serial (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sdata(sdata), .scsN(scsN),
    .frameValid(frameValid), .frameAddr(frameAddr), .frameVal(frameVal)
  );

  pwrseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pwrKeyN(pwrKeyN), .chargerIn(chargerIn),
    .frameValid(frameValid), .frameAddr(frameAddr), .frameVal(frameVal),
    .porDone(porDone), .wdExpired(wdExpired), .state(state), .strobe(strobe)
  );

  pwrseq_datapath #(
    .POR_TICKS(POR_TICKS), .WD_UNIT(WD_UNIT),
    .KILL_TICKS(KILL_TICKS), .WD_DEFAULT(WD_DEFAULT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .frameValid(frameValid), .frameAddr(frameAddr), .frameVal(frameVal),
    .porDone(porDone), .wdExpired(wdExpired), .swBat(swBat), .swChg(swChg),
    .pwmForced(pwmForced), .pwmLevel(pwmLevel)
  );

  assign holding   = (state == PS_HOLD);
  assign released  = (state == PS_RUN) || (state == PS_KILL);
  assign railEn    = (state != PS_OFF);
  assign purxN     = released;
  assign pwmOut    = railEn && (pwmForced || pwmLevel);
  assign sleepCtrl = holding || (released && asicSleep);
  assign chgDetOut = released && chargerIn;
  assign batSwEn   = released && swBat;
  assign chgSwEn   = released && swChg;
endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker (
  input logic clk,
  input logic rstN,
  input logic railEn,
  input logic purxN,
  input logic pwmOut,
  input logic sleepCtrl,
  input logic chgDetOut,
  input logic batSwEn,
  input logic chgSwEn
);
  assert_hold_pwm_R3: assert property (@(posedge clk) disable iff (!rstN)
    (railEn && !purxN) |-> pwmOut);

  assert_hold_sleep_R4: assert property (@(posedge clk) disable iff (!rstN)
    (railEn && !purxN) |-> sleepCtrl);

  assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !railEn |-> (!sleepCtrl && !pwmOut));

  assert_detect_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    !purxN |-> !chgDetOut);

  assert_switches_open_R6: assert property (@(posedge clk) disable iff (!rstN)
    !purxN |-> (!batSwEn && !chgSwEn));

  assert_release_needs_rails_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(purxN) |-> ($past(railEn) && railEn));

  assert_off_holds_reset_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(railEn) |-> !purxN);
endmodule

bind pwrseq_top pwrseq_checker u_chk (.*);

// File: tb/pwrseq_top_bench.sv
module pwrseq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int POR        = 200;
  localparam int UNIT       = 100;
  localparam int KILL       = 20;
  localparam int WDDEF      = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrKeyN = 1'b1;
  logic chargerIn = 1'b0;
  logic asicSleep = 1'b0;
  logic sclk = 1'b0;
  logic sdata = 1'b0;
  logic scsN = 1'b1;
  logic railEn, purxN, pwmOut, sleepCtrl, chgDetOut, batSwEn, chgSwEn;

  int testCnt = 0;
  int failCnt = 0;
  int riseCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge purxN) riseCnt++;

  pwrseq_top #(.POR_TICKS(POR), .WD_UNIT(UNIT), .KILL_TICKS(KILL), .WD_DEFAULT(WDDEF))
  u_pwrseq_top (
    .clk(clk), .rstN(rstN), .pwrKeyN(pwrKeyN), .chargerIn(chargerIn),
    .asicSleep(asicSleep), .sclk(sclk), .sdata(sdata), .scsN(scsN),
    .railEn(railEn), .purxN(purxN), .pwmOut(pwmOut), .sleepCtrl(sleepCtrl),
    .chgDetOut(chgDetOut), .batSwEn(batSwEn), .chgSwEn(chgSwEn)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic batteryReset();
    rstN = 1'b0; pwrKeyN = 1'b1; chargerIn = 1'b0; asicSleep = 1'b0;
    sclk = 1'b0; sdata = 1'b0; scsN = 1'b1;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
  endtask

  task automatic pressKey();
    pwrKeyN = 1'b0;
    waitCyc(2);
    pwrKeyN = 1'b1;
  endtask

  task automatic sendFrame(input logic [1:0] sel, input logic [5:0] val, input int nbits);
    logic [7:0] frame;
    frame = {sel, val};
    scsN = 1'b0;
    waitCyc(2);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdata = frame[i];
      waitCyc(2);
      sclk = 1'b1;
      waitCyc(2);
      sclk = 1'b0;
    end
    waitCyc(1);
    scsN = 1'b1;
    waitCyc(2);
  endtask

  task automatic testReset();
    batteryReset();
    chk("R1", "railEn after reset", railEn, 0);
    chk("R1", "purxN after reset", purxN, 0);
    chk("R1", "pwmOut after reset", pwmOut, 0);
    chk("R4", "sleepCtrl while off", sleepCtrl, 0);
    chk("R5", "chgDetOut after reset", chgDetOut, 0);
  endtask

  task automatic testKeyPowerUp();
    int highCnt;
    batteryReset();
    pressKey();
    chk("R1", "railEn after key press", railEn, 1);
    chk("R2", "purxN at start of hold", purxN, 0);
    chk("R3", "pwmOut forced in hold", pwmOut, 1);
    chk("R4", "sleepCtrl forced in hold", sleepCtrl, 1);
    waitCyc(POR - 12);
    chk("R2", "purxN near end of hold", purxN, 0);
    waitCyc(20);
    chk("R2", "purxN after hold", purxN, 1);
    chk("R3", "pwmOut still forced before duty write", pwmOut, 1);
    asicSleep = 1'b0; waitCyc(1);
    chk("R4", "sleepCtrl follows low request", sleepCtrl, 0);
    asicSleep = 1'b1; waitCyc(1);
    chk("R4", "sleepCtrl follows high request", sleepCtrl, 1);
    sendFrame(2'd2, 6'd0, 8);
    highCnt = 0;
    for (int i = 0; i < 64; i++) begin
      waitCyc(1);
      if (pwmOut) highCnt++;
    end
    chk("R3", "pwm high cycles at duty 0", highCnt, 0);
    sendFrame(2'd2, 6'd16, 8);
    highCnt = 0;
    for (int i = 0; i < 64; i++) begin
      waitCyc(1);
      if (pwmOut) highCnt++;
    end
    chk("R3", "pwm high cycles at duty 16", highCnt, 16);
  endtask

  task automatic testCharger();
    batteryReset();
    waitCyc(1);
    chargerIn = 1'b1;
    waitCyc(2);
    chk("R1", "railEn after charger insert", railEn, 1);
    chk("R5", "chgDetOut masked in hold", chgDetOut, 0);
    waitCyc(POR + 10);
    chk("R5", "chgDetOut after release", chgDetOut, 1);
    chargerIn = 1'b0;
    waitCyc(1);
    chk("R5", "chgDetOut follows removal", chgDetOut, 0);
  endtask

  task automatic testSwitches();
    batteryReset();
    pressKey();
    waitCyc(20);
    sendFrame(2'd0, 6'd3, 8);
    waitCyc(POR);
    chk("R10", "battery switch after frame in hold", batSwEn, 0);
    chk("R10", "charger switch after frame in hold", chgSwEn, 0);
    sendFrame(2'd0, 6'd1, 8);
    chk("R6", "battery switch bit0", batSwEn, 1);
    chk("R6", "charger switch with bit1 clear", chgSwEn, 0);
    sendFrame(2'd0, 6'd2, 8);
    chk("R6", "battery switch with bit0 clear", batSwEn, 0);
    chk("R6", "charger switch bit1", chgSwEn, 1);
    sendFrame(2'd0, 6'd3, 7);
    chk("R10", "short frame ignored bat", batSwEn, 0);
    chk("R10", "short frame ignored chg", chgSwEn, 1);
    sendFrame(2'd3, 6'd63, 8);
    chk("R10", "selector 3 leaves switches bat", batSwEn, 0);
    chk("R10", "selector 3 leaves switches chg", chgSwEn, 1);
  endtask

  task automatic testWatchdogExpiry();
    batteryReset();
    pwrKeyN = 1'b0;
    waitCyc(3300);
    chk("R7", "rails on past timeout measured from press", railEn, 1);
    waitCyc(120);
    chk("R7", "rails off after timeout", railEn, 0);
    chk("R7", "reset low after timeout", purxN, 0);
    waitCyc(200);
    chk("R9", "held key does not restart", railEn, 0);
    pwrKeyN = 1'b1;
    waitCyc(5);
    chk("R9", "key release does not restart", railEn, 0);
    pressKey();
    chk("R9", "fresh key press restarts", railEn, 1);
  endtask

  task automatic testAck();
    batteryReset();
    pressKey();
    waitCyc(POR + 10);
    waitCyc(3000);
    sendFrame(2'd1, 6'd5, 8);
    waitCyc(400);
    chk("R7", "ack extends past default timeout", railEn, 1);
    waitCyc(150);
    chk("R7", "off after acked length", railEn, 0);
    pressKey();
    waitCyc(POR + 450);
    chk("R7", "stored length kept, still on", railEn, 1);
    waitCyc(100);
    chk("R7", "stored length kept, now off", railEn, 0);
  endtask

  task automatic testKill();
    batteryReset();
    pressKey();
    waitCyc(POR + 10);
    sendFrame(2'd1, 6'd0, 8);
    chk("R8", "rails still on right after minimum write", railEn, 1);
    waitCyc(KILL + 5);
    chk("R8", "rails off after minimum write", railEn, 0);
    waitCyc(50);
    chk("R9", "stays off after forced power-off", railEn, 0);
  endtask

  task automatic testCollision();
    int risesBefore;
    batteryReset();
    pressKey();
    waitCyc(POR + 10);
    sendFrame(2'd1, 6'd2, 8);
    sendFrame(2'd1, 6'd0, 8);
    waitCyc(KILL + 10);
    chk("R8", "off before collision run", railEn, 0);
    risesBefore = riseCnt;
    pressKey();
    waitCyc(POR - 10);
    chk("R11", "rails on before coincident edge", railEn, 1);
    waitCyc(20);
    chk("R11", "rails off when hold end meets expiry", railEn, 0);
    chk("R11", "reset never released", riseCnt - risesBefore, 0);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: run did not finish, actual 1 expected 0");
    finishRun();
  end

  initial begin
    testReset();
    testKeyPowerUp();
    testCharger();
    testSwitches();
    testWatchdogExpiry();
    testAck();
    testKill();
    testCollision();
    finishRun();
  end
endmodule